// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a single-rank synchronous DRAM from reset onward. Once reset is released, it keeps the bus quiet for the required power-up settling time. It then closes every bank, runs two refresh cycles and writes the mode word. After that it keeps refreshing the array on a fixed interval for as long as the chip runs. Every spacing between commands is a parameter counted in clock cycles. The settling time and the refresh interval are derived from the clock frequency.

A downstream access engine watches `seq_ready`. While it is high, the engine may run its own transfers, and it raises `access_busy` for the length of each access. When a refresh falls due, the sequencer waits for the current access to finish. It then drops `seq_ready`, closes all banks, refreshes, waits out the row cycle time and hands the bus back. The bank address is always driven zero, and all commands issued here act on every bank.

Top module: `sdram_boot_refresh_seq`

## Requirements
- R1: While `rst_n` is low, and for the two clocks of the reset synchroniser after it rises, chip select is high (deselect), the address is zero and `seq_ready` is low.
- R2: The next WAIT_CYC clocks carry only NOP, with chip select low and the other three strobes high. WAIT_CYC = ceil(PWR_US * CLK_KHZ / 1000).
- R3: The first real command is a precharge: {cs_n,ras_n,cas_n,we_n} = 0010, with address bit 10 high so that it closes all banks.
- R4: A refresh (0001) follows the precharge T_RP clocks later. A second refresh follows T_RC clocks after the first.
- R5: A mode load (0000) follows T_RC clocks after the second refresh. Its address carries burst length on bits 2:0, burst type on bit 3, read latency on bits 6:4, zero on bits 8:7, single-write mode on bit 9 and zero on bits 12:10.
- R6: `seq_ready` stays low until exactly T_MRD clocks after the mode load, then rises.
- R7: A refresh request is raised every REFI_CYC = floor(REFI_NS * CLK_KHZ / 1e6) clocks, counted from the mode load.
- R8: Each refresh request is served by a precharge-all, then a refresh T_RP clocks later. `seq_ready` falls in the cycle of that precharge and stays low until T_RC clocks after the refresh.
- R9: While `access_busy` is high, a pending refresh waits and `seq_ready` stays high. The precharge goes out on the first clock at which `access_busy` is sampled low.
- R10: In any cycle where `seq_ready` is high, the command pins carry NOP.
- R11: Address bit 10 is high only on precharge commands, and the bank address is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| access_busy | input | 1 | High while the downstream engine has an access in flight |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_ba | output | BA_W | Bank address (always zero) |
| sd_addr | output | ADDR_W | Address bus: mode word, or bit 10 for precharge-all |
| seq_ready | output | 1 | Bus granted to the access engine |

## Verification
Two events can land on the same clock: a refresh request first becoming visible, and the access engine releasing `access_busy`. Over successive refresh windows the bench shapes `access_busy` in four ways:
- staying idle;
- holding across the due edge for thirty clocks;
- dropping on exactly the clock after the request registers;
- toggling every three clocks around it.

A cycle-by-cycle reference model predicts the clock on which the precharge-all must appear and the clock on which `seq_ready` must fall. The bench compares every pin against that model on every clock.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_BST   = 4'b0110,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IPRE,
    ST_IREF1,
    ST_IREF2,
    ST_MRS,
    ST_RUN,
    ST_RREF
  } seq_st_e;

  function automatic logic [12:0] mode_word(input int bl, input int bt,
                                            input int cl, input int wb);
    logic [12:0] w;
    w       = '0;
    w[2:0]  = 3'(bl);
    w[3]    = bt[0];
    w[6:4]  = 3'(cl);
    w[9]    = wb[0];
    return w;
  endfunction

endpackage

// File: rtl/sdr_rst_sync.sv
module sdr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sdr_refi_timer.sv
module sdr_refi_timer #(
  parameter int REFI_CYC = 976
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic pend
);
  localparam int TW = $clog2(REFI_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(REFI_CYC - 1);

  logic [TW-1:0] tmr_q, tmr_n;
  logic          pend_q, pend_n;
  logic          expire;

  assign expire = run && (tmr_q == '0);

  always_comb begin
    tmr_n  = tmr_q;
    pend_n = pend_q;
    if (run) tmr_n = expire ? RELOAD : tmr_q - 1'b1;
    if (clr) pend_n = 1'b0;
    if (expire) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= RELOAD;
      pend_q <= 1'b0;
    end else begin
      tmr_q  <= tmr_n;
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

  // R7
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(run));
endmodule

// File: rtl/sdr_cmd_reg.sv
module sdr_cmd_reg
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdr_cmd_e          cmd_d,
  input  logic              a10_d,
  input  logic [ADDR_W-1:0] word_d,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  logic [3:0]        pins_q;
  logic [ADDR_W-1:0] addr_q, addr_n;

  always_comb begin
    addr_n     = word_d;
    addr_n[10] = a10_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= CMD_DESEL;
      addr_q <= '0;
    end else begin
      pins_q <= cmd_d;
      addr_q <= addr_n;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins_q;
  assign addr = addr_q;

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == CMD_PRE) |-> addr[10]);

  // R11
  a10_only_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} != CMD_PRE) |-> !addr[10]);
endmodule

// File: rtl/sdram_boot_refresh_seq.sv
module sdram_boot_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int CLK_KHZ = 125000,
  parameter int PWR_US  = 100,
  parameter int REFI_NS = 7810,
  parameter int T_RP    = 3,
  parameter int T_RC    = 9,
  parameter int T_MRD   = 2,
  parameter int BL_CODE = 3,
  parameter int BT      = 0,
  parameter int CL      = 3,
  parameter int WB_ONE  = 0,
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_busy,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              seq_ready
);
  localparam int WAIT_CYC = (PWR_US * CLK_KHZ + 999) / 1000;
  localparam int REFI_CYC = (REFI_NS * CLK_KHZ) / 1000000;
  localparam int MAX_T1   = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int MAX_T2   = (MAX_T1 > T_MRD) ? MAX_T1 : T_MRD;
  localparam int MAX_G    = (WAIT_CYC > MAX_T2) ? WAIT_CYC : MAX_T2;
  localparam int GAP_W    = $clog2(MAX_G + 1);
  localparam logic [GAP_W-1:0] G_WAIT = GAP_W'(WAIT_CYC);
  localparam logic [GAP_W-1:0] G_RP   = GAP_W'(T_RP - 1);
  localparam logic [GAP_W-1:0] G_RC   = GAP_W'(T_RC - 1);
  localparam logic [GAP_W-1:0] G_MRD  = GAP_W'(T_MRD - 1);
  localparam logic [12:0] MODE13 = mode_word(BL_CODE, BT, CL, WB_ONE);

  logic              rst_i;
  seq_st_e           st_q, st_n;
  logic [GAP_W-1:0]  gap_q, gap_n;
  logic              ready_q, ready_n;
  logic              issue, pend, clr, tmr_run;
  sdr_cmd_e          cmd_n;
  logic              a10_n;
  logic [ADDR_W-1:0] word_n;

  sdr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i)
  );

  assign tmr_run = (st_q == ST_RUN) || (st_q == ST_RREF);

  sdr_refi_timer #(.REFI_CYC(REFI_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_i), .run(tmr_run), .clr(clr), .pend(pend)
  );

  assign issue = (gap_q == '0);

  always_comb begin
    st_n    = st_q;
    gap_n   = issue ? gap_q : gap_q - 1'b1;
    cmd_n   = CMD_NOP;
    a10_n   = 1'b0;
    word_n  = '0;
    ready_n = 1'b0;
    clr     = 1'b0;
    case (st_q)
      ST_IPRE: if (issue) begin
        cmd_n = CMD_PRE; a10_n = 1'b1; gap_n = G_RP; st_n = ST_IREF1;
      end
      ST_IREF1: if (issue) begin
        cmd_n = CMD_REF; gap_n = G_RC; st_n = ST_IREF2;
      end
      ST_IREF2: if (issue) begin
        cmd_n = CMD_REF; gap_n = G_RC; st_n = ST_MRS;
      end
      ST_MRS: if (issue) begin
        cmd_n = CMD_MRS; word_n = ADDR_W'(MODE13); gap_n = G_MRD; st_n = ST_RUN;
      end
      ST_RUN: begin
        if (issue && pend && !access_busy) begin
          cmd_n = CMD_PRE; a10_n = 1'b1; gap_n = G_RP; st_n = ST_RREF; clr = 1'b1;
        end else begin
          ready_n = issue;
        end
      end
      ST_RREF: if (issue) begin
        cmd_n = CMD_REF; gap_n = G_RC; st_n = ST_RUN;
      end
      default: st_n = ST_IPRE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= ST_IPRE;
      gap_q   <= G_WAIT;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      gap_q   <= gap_n;
      ready_q <= ready_n;
    end
  end

  sdr_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_i), .cmd_d(cmd_n), .a10_d(a10_n), .word_d(word_n),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .addr(sd_addr)
  );

  assign sd_ba     = '0;
  assign seq_ready = ready_q;

  // ---- port-level spacing monitor ----
  logic [3:0]       pin_cmd;
  logic [3:0]       last_q;
  logic [GAP_W:0]   since_q;
  logic             is_cmd;
  int               need;

  assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_cmd  = (pin_cmd == CMD_PRE) || (pin_cmd == CMD_REF) || (pin_cmd == CMD_MRS);

  always_comb begin
    case (last_q)
      CMD_PRE: need = T_RP;
      CMD_REF: need = T_RC;
      CMD_MRS: need = T_MRD;
      default: need = 0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      last_q  <= CMD_NOP;
      since_q <= '0;
    end else if (is_cmd) begin
      last_q  <= pin_cmd;
      since_q <= (GAP_W+1)'(1);
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R4 R5 R8
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_i)
    is_cmd |-> (int'(since_q) >= need));

  // R10
  ready_nop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    seq_ready |-> (pin_cmd == CMD_NOP));

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(seq_ready) |-> (pin_cmd == CMD_PRE));

  // R5
  mrs_word_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (pin_cmd == CMD_MRS) |-> (sd_addr[12:10] == 3'b000 && sd_addr[8:7] == 2'b00));
endmodule

// File: tb/sim_sdram_boot_refresh_seq.sv
`timescale 1ns/1ps
module sim_sdram_boot_refresh_seq;
  localparam int CLK_KHZ = 125000;
  localparam int PWR_US  = 100;
  localparam int REFI_NS = 7810;
  localparam int T_RP    = 3;
  localparam int T_RC    = 9;
  localparam int T_MRD   = 2;
  localparam int BL_CODE = 3;
  localparam int BT      = 1;
  localparam int CL      = 2;
  localparam int WB_ONE  = 1;

  localparam int W      = (PWR_US * CLK_KHZ + 999) / 1000;
  localparam int REFI   = (REFI_NS * CLK_KHZ) / 1000000;
  localparam int E_PRE  = W + 1;
  localparam int E_R1   = E_PRE + T_RP;
  localparam int E_R2   = E_R1 + T_RC;
  localparam int E_MRS  = E_R2 + T_RC;
  localparam int E_END  = E_MRS + 13 * REFI;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        access_busy = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #4 clk = ~clk;

  sdram_boot_refresh_seq #(
    .CLK_KHZ(CLK_KHZ), .PWR_US(PWR_US), .REFI_NS(REFI_NS), .T_RP(T_RP),
    .T_RC(T_RC), .T_MRD(T_MRD), .BL_CODE(BL_CODE), .BT(BT), .CL(CL),
    .WB_ONE(WB_ONE), .ADDR_W(13), .BA_W(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .access_busy(access_busy),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_addr(addr), .seq_ready(ready)
  );

  int vectors = 0;
  int fails   = 0;
  int edge_n  = 0;
  int k_now   = -10;
  logic [3:0]  exp_cmd;
  logic [12:0] exp_addr;
  logic        exp_rdy;
  bit          run_m, pend_m;
  int          earliest, ref_at;
  int          ref_seen;
  logic [12:0] mode_exp;

  function automatic logic busy_for(input int k);
    int m, dn;
    if (k <= E_MRS) return 1'b0;
    m  = (k - E_MRS + REFI / 2) / REFI;
    dn = E_MRS + m * REFI;
    case (m % 4)
      1: return (k >= dn - 20 && k < dn + 30);
      2: return (k >= dn - 10 && k <= dn);
      3: return (k >= dn - 15 && k < dn + 15) ? 1'((k / 3) % 2) : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    mode_exp = '0;
    mode_exp[2:0] = 3'(BL_CODE);
    mode_exp[3]   = 1'(BT);
    mode_exp[6:4] = 3'(CL);
    mode_exp[9]   = 1'(WB_ONE);
  end

  // reference model, evaluated at each rising edge
  always @(posedge clk) begin
    bit start, due;
    if (!rst_n) begin
      edge_n = 0; run_m = 0; pend_m = 0; earliest = 0; ref_at = -1;
      k_now = -10;
      exp_cmd = 4'b1111; exp_addr = '0; exp_rdy = 1'b0;
    end else begin
      edge_n++;
      k_now = edge_n - 2;
      exp_addr = '0; exp_rdy = 1'b0;
      if (k_now <= 0) exp_cmd = 4'b1111;
      else begin
        exp_cmd = 4'b0111;
        if (k_now == E_PRE) begin exp_cmd = 4'b0010; exp_addr[10] = 1'b1; end
        if (k_now == E_R1 || k_now == E_R2) exp_cmd = 4'b0001;
        if (k_now == E_MRS) begin
          exp_cmd = 4'b0000; exp_addr = mode_exp;
          run_m = 1; earliest = E_MRS + T_MRD; pend_m = 0;
        end
        if (k_now > E_MRS) begin
          start = run_m && (k_now >= earliest) && pend_m && !access_busy;
          if (start) begin
            exp_cmd = 4'b0010; exp_addr[10] = 1'b1; run_m = 0; ref_at = k_now + T_RP;
          end else if (!run_m && k_now == ref_at) begin
            exp_cmd = 4'b0001; run_m = 1; earliest = k_now + T_RC;
          end else begin
            exp_rdy = run_m && (k_now >= earliest);
          end
          due = ((k_now - E_MRS) % REFI) == 0;
          pend_m = due || (pend_m && !start);
        end
      end
    end
  end

  function automatic string tag_for(input int k, input logic [3:0] ec, input bit rdy_err);
    if (k <= 0)                 return "R1";
    if (k < E_PRE)              return "R2";
    if (k == E_PRE)             return "R3";
    if (k == E_R1 || k == E_R2) return "R4";
    if (k == E_MRS)             return "R5";
    if (rdy_err && k <= E_MRS + T_MRD) return "R6";
    if (rdy_err)                return "R9";
    if (ec == 4'b0010)          return "R7,R8";
    if (ec == 4'b0001)          return "R8";
    return "R10";
  endfunction

  // compare away from the active edge, then drive the next input
  always @(negedge clk) begin
    logic [3:0] act;
    act = {cs_n, ras_n, cas_n, we_n};
    vectors++;
    if (act !== exp_cmd) begin
      fails++;
      $display("FAIL %s k=%0d cmd act=%b exp=%b", tag_for(k_now, exp_cmd, 0), k_now, act, exp_cmd);
    end
    if (addr !== exp_addr) begin
      fails++;
      $display("FAIL %s k=%0d addr act=%h exp=%h",
               (exp_cmd == 4'b0000) ? "R5" : "R11", k_now, addr, exp_addr);
    end
    if (ba !== 2'b00) begin
      fails++;
      $display("FAIL R11 k=%0d ba act=%b exp=00", k_now, ba);
    end
    if (ready !== exp_rdy) begin
      fails++;
      $display("FAIL %s k=%0d ready act=%b exp=%b", tag_for(k_now, exp_cmd, 1), k_now, ready, exp_rdy);
    end
    if (rst_n && k_now > E_MRS && act == 4'b0001) ref_seen++;
    access_busy <= rst_n ? busy_for(k_now + 1) : 1'b0;
  end

  initial begin
    int cyc;
    ref_seen = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (k_now < E_END && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 60000) begin
      fails++;
      $display("FAIL watchdog k=%0d act=timeout exp=end", k_now);
    end
    // R7: one refresh per interval after the mode load (13 intervals, the last may be pending)
    vectors++;
    if (ref_seen < 12 || ref_seen > 13) begin
      fails++;
      $display("FAIL R7 refresh count act=%0d exp=12..13", ref_seen);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule